// File: doc/BRIEF.md
# ChaCha-family Sixteen-Word Permutation Core

This block applies the HChaCha20 permutation to a state of sixteen 32-bit words. A caller assembles the state (constants, key and nonce words) outside the block and presents it as one 512-bit bus together with a one-cycle start strobe. The core captures the state and then runs its single quarter-round unit once per clock. The unit follows a fixed schedule: a column pass of four quarter-rounds, then a diagonal pass of four, repeated for ten double rounds. When the last quarter-round has been written back, the core raises a one-cycle completion pulse. From that cycle on, the output bus holds the permuted state.

The core returns the bare permutation. It does not add the input state back in, and it does not select any subset of the output words. Both of those steps belong to the caller. While a run is in progress the core ignores further start strobes.

Top module: `hchacha_perm_core`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and `state_o` is all zeros.
- R2: A high `start_i` sampled at a rising edge while `busy_o` is low captures `state_i` into the working state and raises `busy_o` from that edge on.
- R3: `busy_o` falls and `done_o` rises on the 80th rising edge after the edge that captured the state. `done_o` stays high for exactly one cycle.
- R4: A high `start_i` sampled while `busy_o` is high has no effect on the run's timing or on its result.
- R5: Each quarter-round on words (a,b,c,d) performs, in this order: a=a+b, d=rotl(d^a,16); c=c+d, b=rotl(b^c,12); a=a+b, d=rotl(d^a,8); c=c+d, b=rotl(b^c,7). All additions are modulo 2^32.
- R6: The column pass processes the word groups (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15), in that order, one per cycle.
- R7: The diagonal pass processes the word groups (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14), in that order, one per cycle, after the column pass.
- R8: A run consists of exactly ten column-then-diagonal double rounds. The result is the permuted state with no addition of the input state.
- R9: On both 512-bit buses, word n occupies bits 32n+31 down to 32n, so word 0 sits in bits 31:0.
- R10: While `busy_o` is low and no start is accepted, `state_o` keeps its value, so the result stays readable after `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| state_i | input | 512 | Input state, word n in bits 32n+31:32n |
| busy_o | output | 1 | High while a permutation is running |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| state_o | output | 512 | Working state; holds the result once idle |

## Verification
Most internal faults show up only in the final state. A wrong word index, a wrong rotate amount or a misordered pass is invisible during a run and appears at `state_o` in the cycle `done_o` rises. Because the permutation diffuses well, a single fault changes nearly every output word. Faults in the step counter or the start gating show up sooner, as a `busy_o` or `done_o` edge that is off by one or more cycles. The bench compares those two outputs on every clock against a reference model. While idle it also compares the whole output state.

// File: rtl/hchacha_pkg.sv
package hchacha_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 16;
    localparam int LANES     = 4;

    typedef logic [WORD_W-1:0] word_t;

    // rotate a word left by a fixed amount
    function automatic word_t rotl(input word_t w, input int unsigned amt);
        return (w << amt) | (w >> (WORD_W - amt));
    endfunction

endpackage

// File: rtl/hchacha_sched.sv
// Maps the low step bits to the four word indices of the current quarter-round.
// slot[2] = 0 selects the column pass, 1 the diagonal pass; slot[1:0] is the group.
module hchacha_sched #(
    parameter int NW    = 16,
    parameter int LN    = 4,
    localparam int IDX_W = $clog2(NW),
    localparam int GRP_W = $clog2(LN)
) (
    input  logic [GRP_W:0]             slot,
    output logic [LN-1:0][IDX_W-1:0]   idx
);
    localparam int ROW = NW / LN;

    logic             diag;
    logic [GRP_W-1:0] grp;

    assign diag = slot[GRP_W];
    assign grp  = slot[GRP_W-1:0];

    for (genvar g = 0; g < LN; g++) begin : g_lane
        logic [GRP_W-1:0] col;
        // diagonal lanes shift their column by the lane number, wrapping in the row
        assign col    = diag ? GRP_W'(grp + GRP_W'(g)) : grp;
        assign idx[g] = IDX_W'(g * ROW) + IDX_W'(col);
    end

endmodule

// File: rtl/hchacha_qr.sv
// One full quarter-round as a combinational datapath.
module hchacha_qr
    import hchacha_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    input  word_t c_i,
    input  word_t d_i,
    output word_t a_o,
    output word_t b_o,
    output word_t c_o,
    output word_t d_o
);
    word_t a1, b1, c1, d1, a2, c2;

    always_comb begin
        a1  = a_i + b_i;
        d1  = rotl(d_i ^ a1, 16);
        c1  = c_i + d1;
        b1  = rotl(b_i ^ c1, 12);
        a2  = a1 + b1;
        d_o = rotl(d1 ^ a2, 8);
        c2  = c1 + d_o;
        b_o = rotl(b1 ^ c2, 7);
        a_o = a2;
        c_o = c2;
    end

endmodule

// File: rtl/hchacha_perm_core.sv
module hchacha_perm_core
    import hchacha_pkg::*;
#(
    parameter int DOUBLE_ROUNDS = 10,
    localparam int STATE_W = WORD_W * NUM_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [STATE_W-1:0] state_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [STATE_W-1:0] state_o
);
    localparam int STEPS = DOUBLE_ROUNDS * 2 * LANES;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam int GRP_W = $clog2(LANES);

    typedef struct packed {
        logic                        busy;
        logic                        done;
        logic [CNT_W-1:0]            step;
        word_t [NUM_WORDS-1:0]       st;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [LANES-1:0][IDX_W-1:0] idx;
    word_t [LANES-1:0]           qin, qout;

    hchacha_sched #(.NW(NUM_WORDS), .LN(LANES)) u_sched (
        .slot (ctx_q.step[GRP_W:0]),
        .idx  (idx)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign qin[g] = ctx_q.st[idx[g]];
    end

    hchacha_qr u_qr (
        .a_i (qin[0]), .b_i (qin[1]), .c_i (qin[2]), .d_i (qin[3]),
        .a_o (qout[0]), .b_o (qout[1]), .c_o (qout[2]), .d_o (qout[3])
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        if (ctx_q.busy) begin
            for (int g = 0; g < LANES; g++) begin
                ctx_d.st[idx[g]] = qout[g];
            end
            if (ctx_q.step == CNT_W'(STEPS - 1)) begin
                ctx_d.busy = 1'b0;
                ctx_d.done = 1'b1;
                ctx_d.step = '0;
            end else begin
                ctx_d.step = ctx_q.step + 1'b1;
            end
        end else if (start_i) begin
            ctx_d.st   = state_i;
            ctx_d.busy = 1'b1;
            ctx_d.step = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy_o  = ctx_q.busy;
    assign done_o  = ctx_q.done;
    assign state_o = ctx_q.st;

endmodule

// File: rtl/hchacha_perm_chk.sv
module hchacha_perm_chk #(
    parameter int STATE_W = 512,
    parameter int STEPS   = 80
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [STATE_W-1:0] state_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [STATE_W-1:0] state_o
);
    int unsigned run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                 run_cnt <= 0;
        else if (start_i && !busy_o) run_cnt <= 0;
        else if (busy_o)            run_cnt <= run_cnt + 1;
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && state_o == $past(state_i)));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R3 and R4: a run counted from its accepted start lasts exactly STEPS edges
    a_r4_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> run_cnt == STEPS);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(state_o));

endmodule

bind hchacha_perm_core hchacha_perm_chk #(
    .STATE_W (STATE_W),
    .STEPS   (STEPS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .state_i (state_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .state_o (state_o)
);

// File: tb/sim_hchacha_perm_core.sv
`timescale 1ns/1ps
module sim_hchacha_perm_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_r = 1'b0;
    logic [511:0] state_r = '0;
    logic         busy_w, done_w;
    logic [511:0] out_w;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    hchacha_perm_core u0 (
        .clk (clk), .rst_n (rst_n), .start_i (start_r), .state_i (state_r),
        .busy_o (busy_w), .done_o (done_w), .state_o (out_w)
    );

    // word groups, columns first then diagonals (R6, R7)
    int grp [8][4] = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
                       '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};

    function automatic logic [31:0] rl(input logic [31:0] w, input int s);
        return (w << s) | (w >> (32 - s));
    endfunction

    // behavioural permutation: R5 steps, R8 ten double rounds, no feed-forward
    function automatic logic [511:0] perm(input logic [511:0] v);
        logic [31:0] x [16];
        logic [511:0] r;
        for (int i = 0; i < 16; i++) x[i] = v[32*i +: 32];   // R9 word placement
        for (int rnd = 0; rnd < 10; rnd++) begin
            for (int q = 0; q < 8; q++) begin
                int a, b, c, d;
                a = grp[q][0]; b = grp[q][1]; c = grp[q][2]; d = grp[q][3];
                x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 16);
                x[c] = x[c] + x[d]; x[b] = rl(x[b] ^ x[c], 12);
                x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 8);
                x[c] = x[c] + x[d]; x[b] = rl(x[b] ^ x[c], 7);
            end
        end
        for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i];
        return r;
    endfunction

    // cycle model
    logic         m_busy = 1'b0, m_done = 1'b0;
    int           m_cnt = 0;
    logic [511:0] m_out = '0, m_pend = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_out = '0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 80) begin
                    m_busy = 1'b0; m_done = 1'b1; m_out = m_pend;
                end
            end else if (start_r) begin
                m_busy = 1'b1; m_cnt = 0; m_pend = perm(state_r);
            end
        end
    end

    task automatic check1(input logic ok, input string req, input logic [511:0] act,
                          input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check1(busy_w == m_busy, "R2 R4 busy", 512'(busy_w), 512'(m_busy));
            check1(done_w == m_done, "R3 done",    512'(done_w), 512'(m_done));
            if (!m_busy)
                check1(out_w == m_out, "R5 R6 R7 R8 R9 R10 state", out_w, m_out);
        end
    end

    task automatic kick(input logic [511:0] v);
        @(negedge clk);
        state_r = v; start_r = 1'b1;
        @(negedge clk);
        start_r = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!m_done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        logic [511:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check1(!busy_w && !done_w && out_w == '0, "R1 reset", {out_w, busy_w, done_w}, '0);
        rst_n = 1'b1;

        kick('0); wait_done();
        for (int i = 0; i < 16; i++) v[32*i +: 32] = 32'(i) * 32'h01010101;
        kick(v); wait_done();
        v = '0; v[0] = 1'b1;                       // R9: only bit 0 of word 0 set
        kick(v); wait_done();
        kick({16{32'hffff_ffff}}); wait_done();
        v = {32'h0a0b0c0d, 32'h90807060, 32'h0, 32'h12345678, {8{32'hdeadbeef}},
             32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};
        kick(v); wait_done();
        // R10: result held over idle cycles
        repeat (10) @(negedge clk);
        // R4: start pulses during a run are ignored
        kick(v ^ {16{32'h5a5a5a5a}});
        repeat (7) @(negedge clk);
        state_r = '1; start_r = 1'b1;
        repeat (3) @(negedge clk);
        start_r = 1'b0;
        wait_done();
        // start in the done cycle is accepted (R2, R3)
        state_r = {16{32'h13579bdf}}; start_r = 1'b1;
        @(negedge clk);
        start_r = 1'b0;
        wait_done();
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R3 actual=%0d expected<20000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule